// File: doc/BRIEF.md
# Booth-Wallace Complex Multiplier

This block multiplies two complex numbers, x = x_re + j·x_im and y = y_re + j·y_im. It produces the real part x_re·y_re − x_im·y_im and the imaginary part x_re·y_im + x_im·y_re, and it uses no dedicated multiplier hardware. Each of the four real products is built from radix-4 Booth digits taken from the y operand. Every digit selects 0, ±1 or ±2 times the x operand. The subtraction in the real part costs no extra adder, because the Booth signs of the x_im·y_im product are inverted.

Each output part has a single reduction tree. The tree takes the rows of the part's two products, one negation-carry row per product, and one constant row that replaces the sign extension of every row. Levels of 6:3 counters reduce this set to two rows, and one carry-propagate adder adds those two rows. Each result is 2N+1 bits wide, which holds the sum of two full N×N products without overflow.

Operands arrive on a valid/ready stream and results leave on a valid/ready stream. The upstream side must hold the operands stable while `in_valid` is high and `in_ready` is low. The block holds the results stable while `out_valid` is high and `out_ready` is low. The `PIPE_MID` parameter adds an optional register between the trees and the adders. The latency is 1 + `PIPE_MID` cycles.

Top module: `cmul_booth_wallace`

## Requirements
- R1: `p_re` equals x_re·y_re − x_im·y_im exactly, with all operands taken as two's-complement signed N-bit values and the result as a signed (2N+1)-bit value.
- R2: `p_im` equals x_re·y_im + x_im·y_re exactly, in the same signed encoding as R1.
- R3: When every operand is the most negative N-bit value (only bit N−1 set), `p_re` is 0 and `p_im` is 2^(2N−1). Mixed most-negative and most-positive operands also give exact results.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `p_re`/`p_im` do not change on the next cycle.
- R5: With `out_ready` held high, an operand set accepted on one clock edge appears with `out_valid` high exactly 1 + `PIPE_MID` edges later. A new operand set can be accepted on every cycle.
- R6: `in_ready` is high in every cycle in which `out_ready` is high.
- R7: After reset, `out_valid` is low and `in_ready` is high.
- R8: Every accepted operand set yields exactly one result, and the results come out in acceptance order. None are dropped or repeated under any back-pressure pattern.
- R9: Each 6:3 counter level keeps the modulo-2^(2N+1) sum of its rows unchanged. The final two rows therefore add up to the exact result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block accepts an operand set this cycle |
| x_re | input | N | Real part of x, signed |
| x_im | input | N | Imaginary part of x, signed |
| y_re | input | N | Real part of y, signed (Booth-recoded) |
| y_im | input | N | Imaginary part of y, signed (Booth-recoded) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |
| p_re | output | 2N+1 | Real part of the product, signed |
| p_im | output | 2N+1 | Imaginary part of the product, signed |

## Verification
Two situations are hard to reach from the ports, and the stimulus must combine them. The first is a full pipeline: the middle register and the output register both hold data while `out_ready` is low and a new operand set is waiting. The second is a Booth group that selects ±2 times a most-negative multiplicand. That term reaches magnitude 2^N, and its inverted form only sums correctly through the separate negation row and the constant row. The stimulus drops `out_ready` at random for about 40% of cycles, so stalls of several cycles occur. It also injects most-negative and most-positive operand sets while those stalls are in progress, and a behavioural queue model compares every popped result exactly.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // number of output rows produced by one counter fed with k rows
  function automatic int grp_rows(int k);
    if (k <= 0) return 0;
    else if (k == 1) return 1;
    else if (k <= 3) return 2;
    else return 3;
  endfunction

  // rows left after one level of 6:3 counters
  function automatic int next_rows(int r);
    return 3 * (r / 6) + grp_rows(r % 6);
  endfunction

  function automatic int rows_after(int r0, int lv);
    int r;
    r = r0;
    for (int i = 0; i < lv; i++) r = next_rows(r);
    return r;
  endfunction

  function automatic int tree_levels(int r0);
    int r;
    int n;
    r = r0;
    n = 0;
    while (r > 2) begin
      r = next_rows(r);
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/booth_rows.sv
module booth_rows #(
  parameter int N      = 32,
  parameter int W      = 2 * N + 1,
  parameter bit NEGATE = 1'b0
) (
  input  logic [N-1:0]             mcand,
  input  logic [N-1:0]             mplier,
  output logic [N/2-1:0][W-1:0]    rows_o,
  output logic [W-1:0]             neg_o
);
  localparam int NR = N / 2;

  logic [N:0]    ylo;
  logic [N:0]    m1;
  logic [N:0]    m2;
  logic [NR-1:0] negv;

  assign ylo = {mplier, 1'b0};
  assign m1  = {mcand[N-1], mcand};
  assign m2  = {mcand, 1'b0};

  for (genvar i = 0; i < NR; i++) begin : g_row
    logic [2:0] grp;
    logic       one_s;
    logic       two_s;
    logic       neg_s;
    logic [N:0] mag;
    logic [N:0] q;

    assign grp   = ylo[2*i+2 : 2*i];
    assign one_s = grp[0] ^ grp[1];
    assign two_s = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
    // sign of the selected digit, flipped when the product is subtracted
    assign neg_s = grp[2] ^ NEGATE;
    assign mag   = one_s ? m1 : (two_s ? m2 : '0);
    assign q     = mag ^ {(N+1){neg_s}};
    // inverted top bit; the matching constant lives in the part's constant row
    assign rows_o[i] = W'({~q[N], q[N-1:0]}) << (2 * i);
    assign negv[i]   = neg_s;
  end

  always_comb begin
    neg_o = '0;
    for (int i = 0; i < NR; i++) neg_o[2*i] = negv[i];
  end

endmodule

// File: rtl/csa63_level.sv
module csa63_level #(
  parameter int W    = 65,
  parameter int RIN  = 35,
  parameter int ROUT = cmul_pkg::next_rows(RIN)
) (
  input  logic [RIN-1:0][W-1:0]  rows_i,
  output logic [ROUT-1:0][W-1:0] rows_o
);
  localparam int G   = RIN / 6;
  localparam int REM = RIN % 6;

  always_comb begin
    rows_o = '0;
    for (int c = 0; c < W; c++) begin
      for (int g = 0; g <= G; g++) begin
        int         k;
        int         nout;
        logic [2:0] cnt;
        k    = (g < G) ? 6 : REM;
        nout = cmul_pkg::grp_rows(k);
        cnt  = '0;
        for (int j = 0; j < k; j++) cnt = cnt + 3'(rows_i[6*g+j][c]);
        for (int b = 0; b < 3; b++)
          if (b < nout && c + b < W) rows_o[3*g+b][c+b] = cnt[b];
      end
    end
  end

  // R9: the level must keep the weighted row sum unchanged
  logic [W-1:0] sum_in;
  logic [W-1:0] sum_out;
  always_comb begin
    sum_in  = '0;
    sum_out = '0;
    for (int r = 0; r < RIN; r++)  sum_in  = sum_in  + rows_i[r];
    for (int r = 0; r < ROUT; r++) sum_out = sum_out + rows_o[r];
    assert_level_sum_R9: assert (sum_in == sum_out);
  end

endmodule

// File: rtl/wallace63_tree.sv
module wallace63_tree #(
  parameter int W   = 65,
  parameter int RIN = 35
) (
  input  logic [RIN-1:0][W-1:0] rows_i,
  output logic [W-1:0]          sum_o,
  output logic [W-1:0]          car_o
);
  localparam int NLEV = cmul_pkg::tree_levels(RIN);

  for (genvar l = 0; l < NLEV; l++) begin : g_lvl
    localparam int RI = cmul_pkg::rows_after(RIN, l);
    localparam int RO = cmul_pkg::rows_after(RIN, l + 1);
    logic [RI-1:0][W-1:0] rin;
    logic [RO-1:0][W-1:0] rout;

    if (l == 0) begin : g_first
      assign rin = rows_i;
    end else begin : g_next
      assign rin = g_lvl[l-1].rout;
    end

    csa63_level #(.W(W), .RIN(RI), .ROUT(RO)) u_lvl (
      .rows_i (rin),
      .rows_o (rout)
    );
  end

  assign sum_o = g_lvl[NLEV-1].rout[0];
  assign car_o = g_lvl[NLEV-1].rout[1];

endmodule

// File: rtl/cmul_booth_wallace.sv
module cmul_booth_wallace #(
  parameter int N        = 32,
  parameter int PIPE_MID = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N-1:0]     x_re,
  input  logic [N-1:0]     x_im,
  input  logic [N-1:0]     y_re,
  input  logic [N-1:0]     y_im,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*N:0]     p_re,
  output logic [2*N:0]     p_im
);
  localparam int W  = 2 * N + 1;
  localparam int NR = N / 2;
  localparam int R0 = 2 * NR + 3;

  // replaces sign extension of every Booth row of two products
  function automatic logic [W-1:0] sign_comp();
    logic [W-1:0] k;
    k = '0;
    for (int i = 0; i < NR; i++) k = k - (W'(1) << (N + 2 * i));
    return k + k;
  endfunction
  localparam logic [W-1:0] KROW = sign_comp();

  logic [NR-1:0][W-1:0] rr_rows, ri_rows, ir_rows, ii_rows;
  logic [W-1:0]         rr_neg, ri_neg, ir_neg, ii_neg;

  booth_rows #(.N(N), .W(W), .NEGATE(1'b0)) u_pp_rr (
    .mcand(x_re), .mplier(y_re), .rows_o(rr_rows), .neg_o(rr_neg));
  booth_rows #(.N(N), .W(W), .NEGATE(1'b1)) u_pp_ii (
    .mcand(x_im), .mplier(y_im), .rows_o(ii_rows), .neg_o(ii_neg));
  booth_rows #(.N(N), .W(W), .NEGATE(1'b0)) u_pp_ri (
    .mcand(x_re), .mplier(y_im), .rows_o(ri_rows), .neg_o(ri_neg));
  booth_rows #(.N(N), .W(W), .NEGATE(1'b0)) u_pp_ir (
    .mcand(x_im), .mplier(y_re), .rows_o(ir_rows), .neg_o(ir_neg));

  logic [R0-1:0][W-1:0] re_rows, im_rows;
  assign re_rows[NR-1:0]    = rr_rows;
  assign re_rows[2*NR-1:NR] = ii_rows;
  assign re_rows[2*NR]      = rr_neg;
  assign re_rows[2*NR+1]    = ii_neg;
  assign re_rows[2*NR+2]    = KROW;
  assign im_rows[NR-1:0]    = ri_rows;
  assign im_rows[2*NR-1:NR] = ir_rows;
  assign im_rows[2*NR]      = ri_neg;
  assign im_rows[2*NR+1]    = ir_neg;
  assign im_rows[2*NR+2]    = KROW;

  logic [W-1:0] t_re_s, t_re_c, t_im_s, t_im_c;

  wallace63_tree #(.W(W), .RIN(R0)) u_tree_re (
    .rows_i(re_rows), .sum_o(t_re_s), .car_o(t_re_c));
  wallace63_tree #(.W(W), .RIN(R0)) u_tree_im (
    .rows_i(im_rows), .sum_o(t_im_s), .car_o(t_im_c));

  logic         adv_out;
  logic         c_v;
  logic [W-1:0] c_re_s, c_re_c, c_im_s, c_im_c;

  assign adv_out = !out_valid || out_ready;

  if (PIPE_MID != 0) begin : g_mid
    logic         mid_v;
    logic [W-1:0] m_re_s, m_re_c, m_im_s, m_im_c;

    assign in_ready = !mid_v || adv_out;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mid_v <= 1'b0;
      end else if (in_ready) begin
        mid_v <= in_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (in_ready && in_valid) begin
        m_re_s <= t_re_s;
        m_re_c <= t_re_c;
        m_im_s <= t_im_s;
        m_im_c <= t_im_c;
      end
    end

    assign c_v    = mid_v;
    assign c_re_s = m_re_s;
    assign c_re_c = m_re_c;
    assign c_im_s = m_im_s;
    assign c_im_c = m_im_c;

    assert_mid_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> mid_v);
    assert_mid_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_v && out_ready) |=> out_valid);
  end else begin : g_direct
    assign in_ready = adv_out;
    assign c_v      = in_valid;
    assign c_re_s   = t_re_s;
    assign c_re_c   = t_re_c;
    assign c_im_s   = t_im_s;
    assign c_im_c   = t_im_c;

    assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (adv_out) begin
      out_valid <= c_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv_out && c_v) begin
      p_re <= c_re_s + c_re_c;
      p_im <= c_im_s + c_im_c;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(p_re) && $stable(p_im)));

  assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

endmodule

// File: tb/cmul_booth_wallace_tb.sv
module cmul_booth_wallace_tb;
  localparam int N   = 32;
  localparam int W   = 2 * N + 1;
  localparam int LAT = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [N-1:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] p_re, p_im;

  always #2 clk = ~clk;

  cmul_booth_wallace #(.N(N), .PIPE_MID(1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .p_re(p_re), .p_im(p_im)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n_in = 0;
  int n_out = 0;

  logic [W-1:0] q_re[$];
  logic [W-1:0] q_im[$];
  int           q_t[$];
  bit           q_r3[$];
  bit           q_lat[$];

  bit           prev_stall = 1'b0;
  logic [W-1:0] prev_re = '0;
  logic [W-1:0] prev_im = '0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic signed [W-1:0] sx(input logic [N-1:0] v);
    return {{(W-N){v[N-1]}}, v};
  endfunction

  task automatic step(input bit v, input logic [N-1:0] a, input logic [N-1:0] b,
                      input logic [N-1:0] c, input logic [N-1:0] d, input bit ordy,
                      input bit r3, input bit latc, output bit acc);
    logic signed [W-1:0] e_re;
    logic signed [W-1:0] e_im;
    @(negedge clk);
    in_valid  = v;
    x_re      = a;
    x_im      = b;
    y_re      = c;
    y_im      = d;
    out_ready = ordy;
    #1;
    // R6: ready must follow the downstream side
    if (out_ready) chk("R6", W'(in_ready), W'(1));
    // R4: a stalled result must be held
    if (prev_stall) begin
      chk("R4", W'(out_valid), W'(1));
      chk("R4", p_re, prev_re);
      chk("R4", p_im, prev_im);
    end
    if (out_valid && out_ready) begin
      n_out++;
      if (q_re.size() == 0) begin
        chk("R8", W'(1), W'(0));
      end else begin
        chk(q_r3[0] ? "R3" : "R1", p_re, q_re[0]);
        chk(q_r3[0] ? "R3" : "R2", p_im, q_im[0]);
        if (q_lat[0]) chk("R5", W'(cyc - q_t[0]), W'(LAT));
        void'(q_re.pop_front());
        void'(q_im.pop_front());
        void'(q_t.pop_front());
        void'(q_r3.pop_front());
        void'(q_lat.pop_front());
      end
    end
    acc = in_valid && in_ready;
    if (acc) begin
      n_in++;
      e_re = sx(a) * sx(c) - sx(b) * sx(d);
      e_im = sx(a) * sx(d) + sx(b) * sx(c);
      q_re.push_back(e_re);
      q_im.push_back(e_im);
      q_t.push_back(cyc);
      q_r3.push_back(r3);
      q_lat.push_back(latc);
    end
    prev_stall = out_valid && !out_ready;
    prev_re    = p_re;
    prev_im    = p_im;
    cyc++;
  endtask

  task automatic send(input logic [N-1:0] a, input logic [N-1:0] b,
                      input logic [N-1:0] c, input logic [N-1:0] d,
                      input bit r3, input bit latc, input int pct);
    bit acc;
    acc = 1'b0;
    while (!acc) step(1'b1, a, b, c, d, ($urandom % 100) < pct, r3, latc, acc);
  endtask

  task automatic idle(input int n, input int pct);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, '0, ($urandom % 100) < pct, 1'b0, 1'b0, acc);
  endtask

  localparam logic [N-1:0] MN = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MP = {1'b0, {(N-1){1'b1}}};

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R7: idle state after reset
    chk("R7", W'(out_valid), W'(0));
    chk("R7", W'(in_ready), W'(1));

    // directed corners, back-to-back, latency checked (R5)
    send(MN, MN, MN, MN, 1'b1, 1'b1, 100);
    send('0, '0, '0, '0, 1'b0, 1'b1, 100);
    send(MP, MP, MP, MP, 1'b1, 1'b1, 100);
    send(MN, MP, MN, MP, 1'b1, 1'b1, 100);
    send(MP, MN, MN, MP, 1'b1, 1'b1, 100);
    send('1, 32'd1, 32'd2, '1, 1'b0, 1'b1, 100);
    send(32'd3, -32'sd5, 32'd7, 32'd11, 1'b0, 1'b1, 100);
    for (int i = 0; i < 24; i++)
      send($urandom, $urandom, $urandom, $urandom, 1'b0, 1'b1, 100);
    idle(LAT + 2, 100);

    // full pipeline: stop the consumer with inputs waiting (R4, R8)
    begin
      bit acc;
      for (int i = 0; i < 8; i++) step(1'b1, MN, MN, MN, MN, 1'b0, 1'b1, 1'b0, acc);
    end
    idle(LAT + 2, 100);

    // random back-pressure with corner operands mixed in (R1, R2, R3, R4, R8)
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0) idle(1 + $urandom % 3, 60);
      case ($urandom % 8)
        0:       send(MN, MN, MN, MN, 1'b1, 1'b0, 60);
        1:       send(MN, MP, MP, MN, 1'b1, 1'b0, 60);
        default: send($urandom, $urandom, $urandom, $urandom, 1'b0, 1'b0, 60);
      endcase
    end
    for (int i = 0; i < 50 && q_re.size() != 0; i++) idle(1, 100);
    idle(2, 100);

    // R8: nothing left over, nothing extra
    chk("R8", W'(q_re.size()), W'(0));
    chk("R8", W'(n_out), W'(n_in));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule